// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block is a bank of per-event statistics counters for a 10 Gb Ethernet MAC. Receive and transmit logic drive one increment lane per counter each cycle. Frame counters step by one. Octet counters add a byte count of up to 16. Software reaches the bank through a plain 16-bit register port. It writes a control word to freeze every counter into a holding copy, or to zero the live counts. It then reads each counter as several 16-bit words.

Each counter has a sticky rollover flag that records when the count wraps. Software polls the flags, or takes an interrupt from them, and extends the hardware count in its own wider total. The flags are packed into a 64-bit vector that reads as four clear-on-read words. A mask of the same shape gates the interrupt line.

The register port is a simple command interface, not a stream. A read or write completes in the cycle it is presented, there is no back-pressure, and the increment lanes are sampled every cycle without a handshake.

Top module: `stat_counter_bank`

## Requirements
- R1: Counter i (width CTR_W, default 40) is read at address 0x10 + 4*i. Offset +0 returns bits 15:0 and offset +1 returns bits 31:16. Offset +2 returns bits 39:32 in its low byte with the upper byte zero, and offset +3 returns zero.
- R2: Writing address 0x00 with bit 0 set copies every live count into its holding register. The copy takes the value from before that cycle's increments. Counter reads return the holding value, which is unchanged until the next snapshot.
- R3: Writing address 0x00 with bit 1 set zeroes every live count on the next edge. An increment presented in that same cycle is discarded, and the holding values are not touched.
- R4: A frame (non-octet) counter advances by exactly one in each cycle its lane is nonzero, whatever the lane's value.
- R5: An octet counter, marked by a set bit in OCTET_MASK (default bits 0, 14, 16 and 23), adds its lane value, from 0 to 16, each cycle.
- R6: When a counter wraps past its maximum, it continues modulo 2^CTR_W and sets rollover flag bit i.
- R7: The rollover vector is read at addresses 0x01 to 0x04. Address 0x01+w returns flags 16w+15 down to 16w. A read clears only the word that was read.
- R8: A flag that is set in the same cycle its word is read is not lost. That read returns the old word, and the flag remains set for the next read.
- R9: Mask words at 0x05 to 0x08 are written and read back in the same layout as the flags, and reset to zero. irq is high while any flag has its mask bit set, so an all-zero mask keeps irq low.
- R10: reg_rdata is updated at the clock edge that samples reg_rd and holds otherwise. Reads of the control word or of unmapped addresses return zero. After reset, every count, holding value, flag and mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctr_add | input | NUM_CTR*5 | Per-counter increment lanes, lane i at bits 5i+4:5i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one edge after reg_rd |
| irq | output | 1 | Masked rollover interrupt |

## Verification
Live counts, holding values, flags and masks each change at the first clock edge after their stimulus. irq follows the flag and mask registers with no further delay. Read data appears at the edge that samples reg_rd. The bench drives every input at the falling edge and samples at the next falling edge, so each result is checked exactly one edge after the stimulus. To keep wrap tests short, the bench builds the bank with an 18-bit counter width. An octet lane at 16 per cycle then wraps after 16384 cycles, and a counter can be parked at fifteen below its maximum so that it wraps in the very cycle its flag word is read.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 8;
  localparam int ADD_W      = 5;
  localparam int ROLL_W     = 64;
  localparam int ROLL_WORDS = ROLL_W / WORD_W;
  localparam int STRIDE_LG2 = 2;
  localparam int EXT_W      = 48;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_ROLL0 = 8'h01;
  localparam logic [ADDR_W-1:0] ADR_MASK0 = 8'h05;
  localparam logic [ADDR_W-1:0] ADR_CTR0  = 8'h10;

  localparam int CTRL_SNAP_BIT = 0;
  localparam int CTRL_CLR_BIT  = 1;

  typedef enum logic [2:0] {RG_NONE, RG_CTRL, RG_ROLL, RG_MASK, RG_CTR} region_e;
endpackage

// File: rtl/stat_ctr_cell.sv
module stat_ctr_cell #(
  parameter int CTR_W    = 40,
  parameter int ADD_W    = 5,
  parameter bit IS_OCTET = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADD_W-1:0] add,
  input  logic             clr,
  input  logic             snap,
  output logic [CTR_W-1:0] live,
  output logic [CTR_W-1:0] hold,
  output logic             wrap
);
  logic [ADD_W-1:0] step;
  logic [CTR_W:0]   sum;

  generate
    if (IS_OCTET) begin : g_octet
      assign step = add;
    end else begin : g_frame
      assign step = ADD_W'(|add);
    end
  endgenerate

  assign sum  = {1'b0, live} + (CTR_W+1)'(step);
  assign wrap = sum[CTR_W] & ~clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      hold <= '0;
    end else begin
      live <= clr ? '0 : sum[CTR_W-1:0];
      if (snap) hold <= live;
    end
  end
endmodule

// File: rtl/stat_roll_flags.sv
module stat_roll_flags #(
  parameter int NUM_CTR = 24
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [NUM_CTR-1:0]                            wrap,
  input  logic [stat_pkg::ROLL_WORDS-1:0]               rd_word_clr,
  input  logic [stat_pkg::ROLL_WORDS-1:0]               mask_we,
  input  logic [stat_pkg::WORD_W-1:0]                   mask_wdata,
  output logic [stat_pkg::ROLL_W-1:0]                   roll,
  output logic [stat_pkg::ROLL_W-1:0]                   mask,
  output logic                                          irq
);
  import stat_pkg::*;

  logic [ROLL_W-1:0] set_bits;
  logic [ROLL_W-1:0] clr_bits;

  always_comb begin
    set_bits = '0;
    set_bits[NUM_CTR-1:0] = wrap;
  end

  generate
    for (genvar w = 0; w < ROLL_WORDS; w++) begin : g_word
      assign clr_bits[w*WORD_W +: WORD_W] = {WORD_W{rd_word_clr[w]}};

      always_ff @(posedge clk) begin
        if (!rst_n) mask[w*WORD_W +: WORD_W] <= '0;
        else if (mask_we[w]) mask[w*WORD_W +: WORD_W] <= mask_wdata;
      end
    end
  endgenerate

  // a new wrap outranks the read-clear of its word
  always_ff @(posedge clk) begin
    if (!rst_n) roll <= '0;
    else        roll <= (roll & ~clr_bits) | set_bits;
  end

  assign irq = |(roll & mask);
endmodule

// File: rtl/stat_read_mux.sv
module stat_read_mux #(
  parameter int NUM_CTR = 24,
  parameter int CTR_W   = 40
) (
  input  logic [stat_pkg::ADDR_W-1:0] addr,
  input  logic [NUM_CTR*CTR_W-1:0]    hold_flat,
  input  logic [stat_pkg::ROLL_W-1:0] roll,
  input  logic [stat_pkg::ROLL_W-1:0] mask,
  output logic [stat_pkg::WORD_W-1:0] rd_word
);
  import stat_pkg::*;

  region_e           region;
  logic [ADDR_W-1:0] ctr_off;
  logic [ADDR_W-1:0] roll_off;
  logic [ADDR_W-1:0] mask_off;
  logic [ADDR_W-STRIDE_LG2-1:0] idx;
  logic [STRIDE_LG2-1:0]        wsel;
  logic [CTR_W-1:0]  sel;
  logic [EXT_W-1:0]  ext;

  assign ctr_off  = addr - ADR_CTR0;
  assign roll_off = addr - ADR_ROLL0;
  assign mask_off = addr - ADR_MASK0;
  assign idx      = ctr_off[ADDR_W-1:STRIDE_LG2];
  assign wsel     = ctr_off[STRIDE_LG2-1:0];

  always_comb begin
    if (addr == ADR_CTRL)                                       region = RG_CTRL;
    else if (addr >= ADR_ROLL0 && int'(roll_off) < ROLL_WORDS)  region = RG_ROLL;
    else if (addr >= ADR_MASK0 && int'(mask_off) < ROLL_WORDS)  region = RG_MASK;
    else if (addr >= ADR_CTR0 && int'(idx) < NUM_CTR)           region = RG_CTR;
    else                                                        region = RG_NONE;
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CTR; i++)
      if (int'(idx) == i) sel = hold_flat[i*CTR_W +: CTR_W];
    ext = '0;
    ext[CTR_W-1:0] = sel;
  end

  always_comb begin
    rd_word = '0;
    unique case (region)
      RG_ROLL: begin
        for (int w = 0; w < ROLL_WORDS; w++)
          if (int'(roll_off) == w) rd_word = roll[w*WORD_W +: WORD_W];
      end
      RG_MASK: begin
        for (int w = 0; w < ROLL_WORDS; w++)
          if (int'(mask_off) == w) rd_word = mask[w*WORD_W +: WORD_W];
      end
      RG_CTR: begin
        case (wsel)
          2'd0:    rd_word = ext[15:0];
          2'd1:    rd_word = ext[31:16];
          2'd2:    rd_word = {8'h00, ext[39:32]};
          default: rd_word = {8'h00, ext[47:40]};
        endcase
      end
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank #(
  parameter int          NUM_CTR    = 24,
  parameter int          CTR_W      = 40,
  parameter logic [63:0] OCTET_MASK = 64'h0000_0000_0081_4001
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_CTR*stat_pkg::ADD_W-1:0] ctr_add,
  input  logic                               reg_wr,
  input  logic                               reg_rd,
  input  logic [stat_pkg::ADDR_W-1:0]        reg_addr,
  input  logic [stat_pkg::WORD_W-1:0]        reg_wdata,
  output logic [stat_pkg::WORD_W-1:0]        reg_rdata,
  output logic                               irq
);
  import stat_pkg::*;

  logic                       do_snap;
  logic                       do_clr;
  logic [NUM_CTR*CTR_W-1:0]   live_flat;
  logic [NUM_CTR*CTR_W-1:0]   hold_flat;
  logic [NUM_CTR-1:0]         wrap;
  logic [ROLL_WORDS-1:0]      rd_word_clr;
  logic [ROLL_WORDS-1:0]      mask_we;
  logic                       roll_rd_any;
  logic [ROLL_W-1:0]          roll;
  logic [ROLL_W-1:0]          mask;
  logic [WORD_W-1:0]          rd_word;

  assign do_snap = reg_wr && reg_addr == ADR_CTRL && reg_wdata[CTRL_SNAP_BIT];
  assign do_clr  = reg_wr && reg_addr == ADR_CTRL && reg_wdata[CTRL_CLR_BIT];

  generate
    for (genvar w = 0; w < ROLL_WORDS; w++) begin : g_dec
      assign rd_word_clr[w] = reg_rd && reg_addr == ADR_ROLL0 + ADDR_W'(w);
      assign mask_we[w]     = reg_wr && reg_addr == ADR_MASK0 + ADDR_W'(w);
    end
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      stat_ctr_cell #(
        .CTR_W    (CTR_W),
        .ADD_W    (ADD_W),
        .IS_OCTET (OCTET_MASK[i])
      ) u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .add  (ctr_add[i*ADD_W +: ADD_W]),
        .clr  (do_clr),
        .snap (do_snap),
        .live (live_flat[i*CTR_W +: CTR_W]),
        .hold (hold_flat[i*CTR_W +: CTR_W]),
        .wrap (wrap[i])
      );
    end
  endgenerate

  assign roll_rd_any = |rd_word_clr;

  stat_roll_flags #(.NUM_CTR(NUM_CTR)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrap       (wrap),
    .rd_word_clr(rd_word_clr),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata),
    .roll       (roll),
    .mask       (mask),
    .irq        (irq)
  );

  stat_read_mux #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_mux (
    .addr     (reg_addr),
    .hold_flat(hold_flat),
    .roll     (roll),
    .mask     (mask),
    .rd_word  (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
  parameter int NUM_CTR = 24,
  parameter int CTR_W   = 40
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        do_snap,
  input logic                        do_clr,
  input logic [NUM_CTR*CTR_W-1:0]    live_flat,
  input logic [NUM_CTR*CTR_W-1:0]    hold_flat,
  input logic [NUM_CTR-1:0]          wrap,
  input logic                        roll_rd_any,
  input logic [stat_pkg::ROLL_W-1:0] roll,
  input logic [stat_pkg::ROLL_W-1:0] mask,
  input logic                        irq
);
  // R2
  snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_snap |=> hold_flat == $past(live_flat));

  // R2
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !do_snap |=> $stable(hold_flat));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> live_flat == '0);

  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> ((roll[NUM_CTR-1:0] & $past(wrap)) == $past(wrap)));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !roll_rd_any |=> ((roll & $past(roll)) == $past(roll)));

  // R9
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

bind stat_counter_bank stat_bank_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .do_snap    (do_snap),
  .do_clr     (do_clr),
  .live_flat  (live_flat),
  .hold_flat  (hold_flat),
  .wrap       (wrap),
  .roll_rd_any(roll_rd_any),
  .roll       (roll),
  .mask       (mask),
  .irq        (irq)
);

// File: tb/test_stat_counter_bank.sv
module test_stat_counter_bank;
  localparam int NUM_CTR = 24;
  localparam int CTR_W   = 18;
  localparam int AW      = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CTR*AW-1:0] ctr_add = '0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [7:0]        reg_addr = '0;
  logic [15:0]       reg_wdata = '0;
  logic [15:0]       reg_rdata;
  logic              irq;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  stat_counter_bank #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) i_stat_counter_bank (
    .clk(clk), .rst_n(rst_n), .ctr_add(ctr_add), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic add_for(input int idx, input logic [4:0] v, input int n);
    @(negedge clk);
    ctr_add[idx*AW +: AW] = v;
    repeat (n) @(negedge clk);
    ctr_add[idx*AW +: AW] = '0;
  endtask

  task automatic read_ctr(input int idx, output logic [47:0] v);
    logic [15:0] w0, w1, w2;
    rd(8'h10 + 8'(idx*4), w0);
    rd(8'h11 + 8'(idx*4), w1);
    rd(8'h12 + 8'(idx*4), w2);
    v = {w2, w1, w0};
  endtask

  task automatic t_reset();
    logic [15:0] d;
    logic [47:0] v;
    read_ctr(0, v);
    check("R10 reset counter", v[31:0], 32'h0);
    rd(8'h01, d); check("R10 reset flags", 32'(d), 32'h0);
    rd(8'h05, d); check("R10 reset mask", 32'(d), 32'h0);
    check("R10 reset irq", 32'(irq), 32'h0);
  endtask

  task automatic t_snapshot();
    logic [47:0] v;
    add_for(3, 5'd1, 7);
    wr(8'h00, 16'h0001);
    add_for(3, 5'd1, 4);
    read_ctr(3, v);
    check("R2 snapshot value", v[31:0], 32'd7);
    wr(8'h00, 16'h0001);
    read_ctr(3, v);
    check("R2 second snapshot", v[31:0], 32'd11);
  endtask

  task automatic t_steps();
    logic [47:0] v;
    add_for(2, 5'd5, 3);
    add_for(0, 5'd16, 2);
    add_for(0, 5'd5, 1);
    wr(8'h00, 16'h0001);
    read_ctr(2, v);
    check("R4 frame counter ignores lane value", v[31:0], 32'd3);
    read_ctr(0, v);
    check("R5 octet counter adds bytes", v[31:0], 32'd37);
  endtask

  task automatic t_clear();
    logic [47:0] v;
    logic [15:0] d;
    wr(8'h00, 16'h0002);
    read_ctr(0, v);
    check("R3 holding untouched by clear", v[31:0], 32'd37);
    @(negedge clk);
    ctr_add[3*AW +: AW] = 5'd1;
    reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 16'h0002;
    @(negedge clk);
    ctr_add[3*AW +: AW] = 5'd0;
    reg_wr = 1'b0; reg_wdata = '0;
    wr(8'h00, 16'h0001);
    read_ctr(3, v);
    check("R3 clear wins over increment", v[31:0], 32'd0);
    rd(8'h00, d);
    check("R10 control reads zero", 32'(d), 32'h0);
  endtask

  task automatic t_layout();
    logic [15:0] d;
    add_for(16, 5'd16, 4500);
    wr(8'h00, 16'h0001);
    rd(8'h50, d); check("R1 word0 bits 15:0", 32'(d), 32'h1940);
    rd(8'h51, d); check("R1 word1 bits 31:16", 32'(d), 32'h0001);
    rd(8'h52, d); check("R1 word2 top bits", 32'(d), 32'h0000);
    rd(8'h53, d); check("R1 word3 zero", 32'(d), 32'h0000);
    rd(8'h90, d); check("R10 unmapped reads zero", 32'(d), 32'h0000);
  endtask

  task automatic t_wrap();
    logic [47:0] v;
    logic [15:0] d;
    wr(8'h00, 16'h0002);
    @(negedge clk);
    ctr_add[0 +: AW] = 5'd16;
    ctr_add[16*AW +: AW] = 5'd16;
    repeat (16384) @(negedge clk);
    ctr_add[0 +: AW] = 5'd0;
    ctr_add[16*AW +: AW] = 5'd0;
    add_for(0, 5'd3, 1);
    wr(8'h00, 16'h0001);
    read_ctr(0, v);
    check("R6 count continues modulo", v[31:0], 32'd3);
    check("R9 irq low under zero mask", 32'(irq), 32'h0);
    wr(8'h05, 16'h0001);
    check("R9 irq on masked flag", 32'(irq), 32'h1);
    rd(8'h05, d); check("R9 mask readback", 32'(d), 32'h0001);
    rd(8'h01, d); check("R6 flag bit 0 set", 32'(d), 32'h0001);
    rd(8'h01, d); check("R7 flag word cleared by read", 32'(d), 32'h0000);
    check("R9 irq drops after clear", 32'(irq), 32'h0);
    rd(8'h02, d); check("R7 other word kept", 32'(d), 32'h0001);
    wr(8'h05, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    wr(8'h00, 16'h0002);
    add_for(0, 5'd16, 16383);
    @(negedge clk);
    ctr_add[0 +: AW] = 5'd16;
    reg_rd = 1'b1; reg_addr = 8'h01;
    @(negedge clk);
    ctr_add[0 +: AW] = 5'd0;
    reg_rd = 1'b0;
    check("R8 read during wrap returns old word", 32'(reg_rdata), 32'h0);
    rd(8'h01, d);
    check("R8 flag kept after colliding read", 32'(d), 32'h0001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_snapshot();
    t_steps();
    t_clear();
    t_layout();
    t_wrap();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule